// File: doc/BRIEF.md
# Selectable Serial-Clock Rate Divider

This block turns a fixed reference clock into a slower serial-bus clock. A two-bit rate code picks one of four divide ratios. With the intended 1.5 MHz reference, the four rates are:

- 100 kHz exactly (divide by 15)
- about 88.2 kHz (divide by 17)
- about 44.1 kHz (divide by 34)
- 1.5 kHz (divide by 1000)

Only one rate runs at a time. A single counter, reloaded from the rate code, times every period. The block drives the divided clock and a one-reference-cycle strobe that marks each rising edge of that clock.

The divided clock has a 50% duty cycle even when the divisor is odd. A phase timed on the rising edge of the reference and a copy of it retimed on the falling edge are ORed together. This stretches the high time by half a reference period. A new rate code is taken only at a period boundary, so a change never cuts a period short or makes a runt pulse.

A small two-state machine times the waveform. The states are PH_LOW and PH_HIGH.

- Reset forces PH_LOW with the count at zero.
- PH_LOW moves to PH_HIGH at the boundary edge, where the count is zero. On that edge the divisor is reloaded from the rate code and the strobe is raised.
- PH_HIGH moves to PH_LOW on the edge where the count equals the high threshold.
- Every other edge keeps the state and decrements the count.

Top module: `scl_rate_div`

## Requirements
- R1: While reset is asserted, the divided clock is low from the reference falling edge after the first reset edge onward, and the rise strobe is low.
- R2: Rate code 00 selects divide-by-15, 01 divide-by-17, 10 divide-by-34 and 11 divide-by-1000: successive rise strobes are exactly N reference cycles apart.
- R3: Over one period of N reference cycles, the divided clock is high for exactly N half-cycles of the reference, for both odd and even N.
- R4: The rise strobe is high for exactly one reference cycle per divided-clock period.
- R5: The rise strobe is high in the same reference cycle in which the divided clock goes from low to high.
- R6: A rate code change made in the middle of a period leaves that period at its old length; the new ratio applies from the next period on.
- R7: The first reference edge after reset is released starts a new period, with strobe and divided clock high; its length follows the rate code present during reset.
- R8: When the rate code changes several times within one period, only the value present at the boundary edge sets the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; both of its edges are used |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Rate code: 00 /15, 01 /17, 10 /34, 11 /1000 |
| scl_clk | output | 1 | Divided clock, 50% duty |
| scl_rise_tick | output | 1 | One-cycle strobe at each rising edge of scl_clk |

## Verification
Reset is taken at a rising reference edge. The rising-edge phase and the strobe respond at the first rising edge after a stimulus. The falling-edge copy follows half a reference period later.

The bench therefore samples twice in each reference cycle: one quarter-period after the rising edge and one quarter-period after the falling edge. This lets it count high time in half-cycle units and see the extra half-cycle that odd divisors add. Changes of rate code and reset are driven three quarters into a cycle, so they are captured by the next rising edge. The expected period of a changed rate is counted from the boundary edge that follows the change. That is one whole old period after the previous strobe, never from the change itself.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/srd_rate_table.sv
module srd_rate_table #(
    parameter int unsigned DIV_0 = 15,
    parameter int unsigned DIV_1 = 17,
    parameter int unsigned DIV_2 = 34,
    parameter int unsigned DIV_3 = 1000,
    parameter int unsigned CW    = 10
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] div,
    output logic [CW-1:0] thr,
    output logic          odd
);
    localparam int unsigned NUM_RATES = 4;

    logic [CW-1:0] div_opt [NUM_RATES];
    logic [CW-1:0] thr_opt [NUM_RATES];
    logic          odd_opt [NUM_RATES];

    // One entry per rate code; the threshold is where the high phase ends:
    // N - floor(N/2) counts remain when the rising-edge phase drops.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_entry
        localparam int unsigned N_G = (g == 0) ? DIV_0 :
                                      (g == 1) ? DIV_1 :
                                      (g == 2) ? DIV_2 : DIV_3;
        assign div_opt[g] = CW'(N_G);
        assign thr_opt[g] = CW'(N_G - (N_G / 2));
        assign odd_opt[g] = (N_G % 2) == 1;
    end

    always_comb begin
        div = div_opt[sel];
        thr = thr_opt[sel];
        odd = odd_opt[sel];
    end

    initial begin
        assert (DIV_0 >= 2 && DIV_1 >= 2 && DIV_2 >= 2 && DIV_3 >= 2)
            else $error("every divisor must be at least 2");
    end

endmodule

// File: rtl/srd_phase_fsm.sv
module srd_phase_fsm
    import scl_rate_pkg::*;
#(
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] new_div,
    input  logic [CW-1:0] new_thr,
    input  logic          new_odd,
    output logic          pos_ph,
    output logic          tick,
    output logic          odd_q
);
    phase_e        state, state_nx;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cur_div;
    logic [CW-1:0] cur_thr;
    logic          at_boundary;
    logic          at_thr;
    logic          tick_q;

    assign at_boundary = (cnt == '0);
    assign at_thr      = (cnt == cur_thr);

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_LOW:  if (at_boundary) state_nx = PH_HIGH;
            PH_HIGH: if (at_thr)      state_nx = PH_LOW;
            default: state_nx = PH_LOW;
        endcase
    end

    // State register together with the period counter and the latched rate.
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PH_LOW;
            cnt     <= '0;
            cur_div <= new_div;
            cur_thr <= new_thr;
            odd_q   <= new_odd;
        end else begin
            state <= state_nx;
            if (at_boundary) begin
                cnt     <= new_div - CW'(1);
                cur_div <= new_div;
                cur_thr <= new_thr;
                odd_q   <= new_odd;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    // Output process: strobe registered on the boundary edge.
    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= at_boundary;
    end

    always_comb begin
        pos_ph = (state == PH_HIGH);
        tick   = tick_q;
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt < cur_div);

    p_rate_held_r6: assert property (@(posedge clk) disable iff (rst)
        !at_boundary |=> $stable(cur_div));

    p_tick_single_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    p_tick_rise_r5: assert property (@(posedge clk) disable iff (rst)
        tick |-> (pos_ph && !$past(pos_ph)));

    p_reset_low_r1: assert property (@(posedge clk)
        $past(rst) && rst |-> (!pos_ph && !tick));

endmodule

// File: rtl/srd_edge_merge.sv
module srd_edge_merge (
    input  logic clk,
    input  logic rst,
    input  logic pos_ph,
    input  logic odd,
    output logic clk_out
);
    logic neg_q;

    // Half-cycle delayed copy of the rising-edge phase.
    always_ff @(negedge clk) begin
        if (rst) neg_q <= 1'b0;
        else     neg_q <= pos_ph;
    end

    assign clk_out = pos_ph | (odd & neg_q);

    p_neg_follow_r3: assert property (@(posedge clk) disable iff (rst)
        neg_q == pos_ph);

endmodule

// File: rtl/scl_rate_div.sv
module scl_rate_div
    import scl_rate_pkg::*;
#(
    parameter int unsigned DIV_0 = 15,
    parameter int unsigned DIV_1 = 17,
    parameter int unsigned DIV_2 = 34,
    parameter int unsigned DIV_3 = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    output logic       scl_clk,
    output logic       scl_rise_tick
);
    localparam int unsigned DIV_MAX = max_of4(DIV_0, DIV_1, DIV_2, DIV_3);
    localparam int unsigned CW      = $clog2(DIV_MAX + 1);

    logic [CW-1:0] sel_div;
    logic [CW-1:0] sel_thr;
    logic          sel_odd;
    logic          pos_ph;
    logic          odd_q;

    srd_rate_table #(
        .DIV_0(DIV_0), .DIV_1(DIV_1), .DIV_2(DIV_2), .DIV_3(DIV_3), .CW(CW)
    ) i_table (
        .sel (rate_sel),
        .div (sel_div),
        .thr (sel_thr),
        .odd (sel_odd)
    );

    srd_phase_fsm #(.CW(CW)) i_fsm (
        .clk     (clk),
        .rst     (rst),
        .new_div (sel_div),
        .new_thr (sel_thr),
        .new_odd (sel_odd),
        .pos_ph  (pos_ph),
        .tick    (scl_rise_tick),
        .odd_q   (odd_q)
    );

    srd_edge_merge i_merge (
        .clk     (clk),
        .rst     (rst),
        .pos_ph  (pos_ph),
        .odd     (odd_q),
        .clk_out (scl_clk)
    );

endmodule

// File: tb/test_scl_rate_div.sv
module test_scl_rate_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rate_sel = 2'b00;
    logic       scl_clk;
    logic       scl_rise_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit hi_a, hi_b, tk, prev_b;

    always #2 clk = ~clk;

    scl_rate_div i_scl_rate_div (
        .clk(clk), .rst(rst), .rate_sel(rate_sel),
        .scl_clk(scl_clk), .scl_rise_tick(scl_rise_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One reference cycle: sample after rising and after falling edge.
    task automatic step();
        prev_b = hi_b;
        @(posedge clk);
        #1 hi_a = scl_clk; tk = scl_rise_tick;
        #2 hi_b = scl_clk;
    endtask

    task automatic wait_tick(output int cyc);
        cyc = 0;
        do begin
            step();
            cyc++;
        end while (!tk && cyc < 3000);
    endtask

    // Starts right after the tick cycle; checks one whole period of length n.
    task automatic measure(input int n, input string tag);
        int highs, ticks;
        highs = int'(hi_a) + int'(hi_b);
        ticks = 1;
        chk(hi_a && !prev_b, {tag, " R5 rise with tick"}, int'(hi_a), 1);
        for (int i = 1; i < n; i++) begin
            step();
            highs += int'(hi_a) + int'(hi_b);
            ticks += int'(tk);
        end
        chk(highs == n, {tag, " R3 high half-cycles"}, highs, n);
        chk(ticks == 1, {tag, " R4 ticks per period"}, ticks, 1);
        step();
        chk(tk == 1'b1, {tag, " R2 period length"}, int'(tk), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk(hi_b == 1'b0, "R1 clock low in reset", int'(hi_b), 0);
        chk(tk == 1'b0, "R1 tick low in reset", int'(tk), 0);
        rst = 1'b0;
        step();
        chk(tk && hi_a, "R7 first edge after release starts period", int'(tk), 1);
        measure(15, "reset-default");
    endtask

    task automatic t_rate(input logic [1:0] s, input int n, input string tag);
        int c;
        rate_sel = s;
        wait_tick(c);
        measure(n, tag);
    endtask

    task automatic t_change_mid();
        int c;
        rate_sel = 2'b11;
        wait_tick(c);
        repeat (100) step();
        rate_sel = 2'b00;
        wait_tick(c);
        chk(c == 900, "R6 old period completes", c, 900);
        measure(15, "R6 new rate");
    endtask

    task automatic t_multi_change();
        int c;
        rate_sel = 2'b11;
        wait_tick(c);
        repeat (50) step();
        rate_sel = 2'b00;
        repeat (250) step();
        rate_sel = 2'b01;
        repeat (300) step();
        rate_sel = 2'b10;
        wait_tick(c);
        chk(c == 400, "R8 period unchanged by edits", c, 400);
        measure(34, "R8 last code wins");
    endtask

    task automatic t_reset_mid();
        int c;
        rate_sel = 2'b11;
        wait_tick(c);
        repeat (10) step();
        rate_sel = 2'b01;
        rst = 1'b1;
        step();
        chk(hi_b == 1'b0, "R1 reset mid-high drives low", int'(hi_b), 0);
        chk(tk == 1'b0, "R1 reset mid-high no tick", int'(tk), 0);
        rst = 1'b0;
        step();
        chk(tk == 1'b1, "R7 tick on first edge after release", int'(tk), 1);
        measure(17, "R7 rate from reset");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        hi_a = 0; hi_b = 0; tk = 0; prev_b = 0;
        t_reset();
        t_rate(2'b00, 15,   "R2 code00");
        t_rate(2'b01, 17,   "R2 code01");
        t_rate(2'b10, 34,   "R2 code10");
        t_rate(2'b11, 1000, "R2 code11");
        t_change_mid();
        t_multi_change();
        t_reset_mid();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule